// File: doc/BRIEF.md
# Integer ALU with Trapping and Non-Trapping Arithmetic

This block is the integer arithmetic unit of a simple load-store processor core. Each clock cycle it takes two 32-bit operands, a 5-bit shift amount and a 4-bit operation code, and one cycle later presents a 32-bit result, an overflow flag and a zero flag. Addition and subtraction come in two kinds that produce the same bit pattern: the trapping kind raises the overflow flag when the signed result does not fit the word, the non-trapping kind never does. Less-than comparison comes in a signed and an unsigned kind. Logical shifts move the first operand left or right by the shift amount and fill the vacated positions with zeros.

The zero flag always reports whether the two operands are equal, which is computed from their difference. Branch-if-equal and branch-if-not-equal logic use it directly whatever operation is selected. Immediate operands arrive already extended; multiply, divide and any trap handling are outside the block.

The datapath is organised around the operation code as a named enumeration, `alu_op_e`. Each value selects one output path in a single unique case, and the outputs are captured in one register stage. After reset the unit is in the cleared condition. From then on, every cycle moves it to the condition that the current operation code names. The named conditions are ADD, ADDU, SUB, SUBU, SLT, SLTU, SLL and SRL, plus an idle condition for unassigned codes.

Top module: `alu_core`

## Requirements
- R1: Operation code 0 (trapping add) gives A+B modulo 2^32 and sets the overflow flag exactly when the signed sum of A and B lies outside the signed 32-bit range.
- R2: Operation code 2 (trapping subtract) gives A-B modulo 2^32 and sets the overflow flag exactly when the signed difference lies outside the signed 32-bit range.
- R3: Operation codes 1 (non-trapping add) and 3 (non-trapping subtract) give the same result bits as codes 0 and 2 respectively, with the overflow flag low.
- R4: Operation code 4 (signed less-than) gives 1 when A is less than B as two's-complement numbers and 0 otherwise, with bits 31..1 of the result zero; A=0xFFFFFFFA, B=0x0000FFFA gives 1.
- R5: Operation code 5 (unsigned less-than) gives 1 when A is less than B as unsigned numbers and 0 otherwise, with bits 31..1 zero; A=0xFFFFFFFA, B=0x0000FFFA gives 0.
- R6: Operation code 6 (left shift) gives A shifted left by the shift amount with zeros entering at bit 0; 0x00000002 shifted by 2 gives 0x00000008.
- R7: Operation code 7 (right shift) gives A shifted right by the shift amount with zeros entering at bit 31.
- R8: The zero flag is high exactly when A minus B is zero, i.e. A equals B, for every operation code.
- R9: The overflow flag is low for every operation code other than 0 and 2; codes 8 to 15 give a result of zero.
- R10: Result and flags are registered: they reflect the inputs present at the previous rising clock edge, and while reset (active low, asynchronous) is asserted the result and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A (also the shifted value) |
| b_i | input | 32 | Operand B |
| shamt_i | input | 5 | Shift amount |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed overflow flag |
| zero_o | output | 1 | Registered operand-equality flag |

## Verification
The bench builds the block with its default width of 32 bits, so the 5-bit shift amount covers every shift distance from 0 to 31. The signed boundary values 0x7FFFFFFF and 0x80000000 can then be driven directly to reach each overflow edge. The operand pair 0xFFFFFFFA and 0x0000FFFA, on which signed and unsigned comparison disagree, can be applied as it is. Random operands that mix sign bits and unassigned operation codes exercise the flag-suppression rules, and directed equal-operand cases exercise the zero flag.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        ALU_ADD  = 4'd0,
        ALU_ADDU = 4'd1,
        ALU_SUB  = 4'd2,
        ALU_SUBU = 4'd3,
        ALU_SLT  = 4'd4,
        ALU_SLTU = 4'd5,
        ALU_SLL  = 4'd6,
        ALU_SRL  = 4'd7
    } alu_op_e;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             sum_ovf_o,
    output logic [WIDTH-1:0] diff_o,
    output logic             diff_ovf_o,
    output logic             lt_signed_o,
    output logic             lt_unsigned_o,
    output logic             diff_zero_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   sum_full;
    logic [WIDTH:0]   diff_full;
    logic [WIDTH-1:0] b_inv;

    always_comb begin
        b_inv     = ~b_i;
        sum_full  = {1'b0, a_i} + {1'b0, b_i};
        diff_full = {1'b0, a_i} + {1'b0, b_inv} + {{WIDTH{1'b0}}, 1'b1};
    end

    always_comb begin
        sum_o         = sum_full[WIDTH-1:0];
        diff_o        = diff_full[WIDTH-1:0];
        // like-signed addends whose sum flips sign
        sum_ovf_o     = (a_i[MSB] == b_i[MSB]) && (sum_full[MSB] != a_i[MSB]);
        // unlike-signed operands whose difference leaves A's sign
        diff_ovf_o    = (a_i[MSB] != b_i[MSB]) && (diff_full[MSB] != a_i[MSB]);
        // carry out of A + ~B + 1 clear means a borrow occurred
        lt_unsigned_o = ~diff_full[WIDTH];
        lt_signed_o   = diff_full[MSB] ^ diff_ovf_o;
        diff_zero_o   = (diff_full[WIDTH-1:0] == '0);
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int WIDTH   = 32,
    parameter bit LEFT    = 1'b1
) (
    input  logic [WIDTH-1:0]         data_i,
    input  logic [$clog2(WIDTH)-1:0] amt_i,
    output logic [WIDTH-1:0]         data_o
);

    localparam int STAGES = $clog2(WIDTH);

    logic [WIDTH-1:0] stage [0:STAGES];

    assign stage[0] = data_i;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (LEFT) begin : g_left
            assign stage[k+1] = amt_i[k] ? (stage[k] << (2 ** k)) : stage[k];
        end else begin : g_right
            assign stage[k+1] = amt_i[k] ? (stage[k] >> (2 ** k)) : stage[k];
        end
    end

    assign data_o = stage[STAGES];

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               op_i,
    input  logic [WIDTH-1:0]         a_i,
    input  logic [WIDTH-1:0]         b_i,
    input  logic [$clog2(WIDTH)-1:0] shamt_i,
    output logic [WIDTH-1:0]         result_o,
    output logic                     ovf_o,
    output logic                     zero_o
);

    localparam int SHW = $clog2(WIDTH);

    alu_op_e          op;
    logic [WIDTH-1:0] sum, diff, shl, shr;
    logic             sum_ovf, diff_ovf, lt_s, lt_u, eq;
    logic [WIDTH-1:0] result_d;
    logic             ovf_d;

    assign op = alu_op_e'(op_i);

    alu_arith #(.WIDTH(WIDTH)) u_arith (
        .a_i           (a_i),
        .b_i           (b_i),
        .sum_o         (sum),
        .sum_ovf_o     (sum_ovf),
        .diff_o        (diff),
        .diff_ovf_o    (diff_ovf),
        .lt_signed_o   (lt_s),
        .lt_unsigned_o (lt_u),
        .diff_zero_o   (eq)
    );

    alu_shift #(.WIDTH(WIDTH), .LEFT(1'b1)) u_shl (
        .data_i (a_i),
        .amt_i  (shamt_i[SHW-1:0]),
        .data_o (shl)
    );

    alu_shift #(.WIDTH(WIDTH), .LEFT(1'b0)) u_shr (
        .data_i (a_i),
        .amt_i  (shamt_i[SHW-1:0]),
        .data_o (shr)
    );

    // output selection, one path per named operation
    always_comb begin
        result_d = '0;
        ovf_d    = 1'b0;
        unique case (op)
            ALU_ADD: begin
                result_d = sum;
                ovf_d    = sum_ovf;
            end
            ALU_ADDU: result_d = sum;
            ALU_SUB: begin
                result_d = diff;
                ovf_d    = diff_ovf;
            end
            ALU_SUBU: result_d = diff;
            ALU_SLT:  result_d = {{(WIDTH-1){1'b0}}, lt_s};
            ALU_SLTU: result_d = {{(WIDTH-1){1'b0}}, lt_u};
            ALU_SLL:  result_d = shl;
            ALU_SRL:  result_d = shr;
            default: begin
                result_d = '0;
                ovf_d    = 1'b0;
            end
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            ovf_o    <= 1'b0;
            zero_o   <= 1'b0;
        end else begin
            result_o <= result_d;
            ovf_o    <= ovf_d;
            zero_o   <= eq;
        end
    end

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [3:0]               op_i,
    input logic [WIDTH-1:0]         a_i,
    input logic [WIDTH-1:0]         b_i,
    input logic [$clog2(WIDTH)-1:0] shamt_i,
    input logic [WIDTH-1:0]         result_o,
    input logic                     ovf_o,
    input logic                     zero_o
);

    localparam int MSB = WIDTH - 1;

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !ovf_o && !zero_o));

    p_add_mixed_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(ALU_ADD) && a_i[MSB] != b_i[MSB]) |=> !ovf_o);

    p_sub_same_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(ALU_SUB) && a_i[MSB] == b_i[MSB]) |=> !ovf_o);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 4'(ALU_ADD) && op_i != 4'(ALU_SUB)) |=> !ovf_o);

    p_nontrap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(ALU_ADDU) || op_i == 4'(ALU_SUBU)) |=> !ovf_o);

    p_slt_bool_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(ALU_SLT)) |=> (result_o[WIDTH-1:1] == '0));

    p_sltu_bool_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(ALU_SLTU)) |=> (result_o[WIDTH-1:1] == '0));

    p_sll_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(ALU_SLL) && shamt_i != '0) |=> !result_o[0]);

    p_srl_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(ALU_SRL) && shamt_i != '0) |=> !result_o[MSB]);

    p_shift_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 4'(ALU_SLL) || op_i == 4'(ALU_SRL)) && shamt_i == '0)
        |=> (result_o == $past(a_i)));

    p_zero_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_i == b_i) |=> zero_o);

    p_zero_differ_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_i != b_i) |=> !zero_o);

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .shamt_i  (shamt_i),
    .result_o (result_o),
    .ovf_o    (ovf_o),
    .zero_o   (zero_o)
);

// File: tb/alu_core_tb.sv
module alu_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        op_i = '0;
    logic [WIDTH-1:0]  a_i = '0;
    logic [WIDTH-1:0]  b_i = '0;
    logic [4:0]        shamt_i = '0;
    logic [WIDTH-1:0]  result_o;
    logic              ovf_o;
    logic              zero_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_core #(.WIDTH(WIDTH)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .shamt_i  (shamt_i),
        .result_o (result_o),
        .ovf_o    (ovf_o),
        .zero_o   (zero_o)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R3";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R9";
        endcase
    endfunction

    function automatic void model(input logic [3:0] op, input logic [31:0] a,
                                  input logic [31:0] b, input logic [4:0] sh,
                                  output logic [31:0] r, output logic ov,
                                  output logic z);
        longint sa, sb, s;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        r  = '0;
        ov = 1'b0;
        z  = (a == b);
        case (op)
            4'd0: begin
                s  = sa + sb;
                r  = a + b;
                ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            4'd1: r = a + b;
            4'd2: begin
                s  = sa - sb;
                r  = a - b;
                ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            4'd3: r = a - b;
            4'd4: r = (sa < sb) ? 32'd1 : 32'd0;
            4'd5: r = (a < b) ? 32'd1 : 32'd0;
            4'd6: r = a << sh;
            4'd7: r = a >> sh;
            default: r = '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act_r,
                         input logic act_o, input logic act_z,
                         input logic [31:0] exp_r, input logic exp_o,
                         input logic exp_z);
        checks++;
        if (act_r !== exp_r || act_o !== exp_o || act_z !== exp_z) begin
            failures++;
            $display("FAIL %s: result=%h ovf=%b zero=%b expected result=%h ovf=%b zero=%b",
                     req, act_r, act_o, act_z, exp_r, exp_o, exp_z);
        end
    endtask

    // drive at a falling edge, check at the next falling edge (one register)
    task automatic apply(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] sh,
                         input string tag);
        logic [31:0] er;
        logic        eo, ez;
        op_i    = op;
        a_i     = a;
        b_i     = b;
        shamt_i = sh;
        model(op, a, b, sh, er, eo, ez);
        @(negedge clk);
        check(tag, result_o, ovf_o, zero_o, er, eo, ez);
    endtask

    initial begin
        logic [31:0] ra, rb;
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        // R10: cleared while reset is held
        op_i = 4'd0; a_i = 32'hFFFF_FFFF; b_i = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R10", result_o, ovf_o, zero_o, 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1 overflow edges
        apply(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, "R1");
        apply(4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, "R1");
        apply(4'd0, 32'h7FFF_FFFE, 32'h0000_0001, 5'd0, "R1");
        // R2 overflow edges
        apply(4'd2, 32'h8000_0000, 32'h0000_0001, 5'd0, "R2");
        apply(4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R2");
        apply(4'd2, 32'h0000_0005, 32'h0000_0007, 5'd0, "R2");
        // R3 same bits, no flag
        apply(4'd1, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, "R3");
        apply(4'd3, 32'h8000_0000, 32'h0000_0001, 5'd0, "R3");
        // R4 / R5 disagreeing pair
        apply(4'd4, 32'hFFFF_FFFA, 32'h0000_FFFA, 5'd0, "R4");
        apply(4'd5, 32'hFFFF_FFFA, 32'h0000_FFFA, 5'd0, "R5");
        apply(4'd4, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, "R4");
        apply(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, "R5");
        // R6 / R7 shifts
        apply(4'd6, 32'h0000_0002, 32'h0, 5'd2, "R6");
        apply(4'd6, 32'hFFFF_FFFF, 32'h0, 5'd31, "R6");
        apply(4'd7, 32'h8000_0000, 32'h0, 5'd31, "R7");
        apply(4'd7, 32'hFFFF_FFFF, 32'h0, 5'd0, "R7");
        // R8 zero flag across codes
        apply(4'd6, 32'h1234_5678, 32'h1234_5678, 5'd4, "R8");
        apply(4'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, "R8");
        // R9 unassigned codes
        apply(4'd8,  32'h7FFF_FFFF, 32'h0000_0001, 5'd3, "R9");
        apply(4'd15, 32'h8000_0000, 32'h0000_0001, 5'd3, "R9");

        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            ra = $urandom;
            rb = ($urandom_range(0, 7) == 0) ? ra : $urandom;
            apply(op, ra, rb, 5'($urandom_range(0, 31)), req_of(op));
        end

        // R10 reset clears again mid-run
        op_i = 4'd0; a_i = 32'h7FFF_FFFF; b_i = 32'h7FFF_FFFF;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10", result_o, ovf_o, zero_o, 32'h0, 1'b0, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule